// File: doc/BRIEF.md
# Virtual Pixel Address Generator

This block produces pixel addresses for an array chip that serves far more pixels than it has processing elements. The image is divided among several chips, and each chip gets one unbroken run of pixels. The size of that run is the image size divided by the chip count, rounded up. The run that falls at the end of the image is cut short at the image size. Inside its run, the chip advances in steps. On each step, element `p` works on pixel `p` of a group of `NPE` consecutive pixels, and the next step moves on by `NPE` pixels. Over the whole run, each element therefore visits every `NPE`-th pixel of the chip's run.

Software pulses `start` with four values: the chip number, the chip count, the image size and a prefetch distance. The block works out the run with a short bit-serial division. It then presents one step per beat on a ready/valid output. Each beat carries all `NPE` element addresses, a per-element valid mask, the step number and a last-step flag. Each beat also carries a look-ahead address: the first pixel of the step that lies the prefetch distance ahead. The memory side uses it to fetch data before it is needed. Because the prefetch rides on the same beat, it is only offered while its target step still lies inside the chip's run.

Top module: `vpix_addr_gen`

## Requirements
- R1: The run length per chip is `ceil(img_pixels / num_chips)`. The chip's first pixel (its base) is `chip_idx` times that length.
- R2: The chip's length is the smaller of the run length and `img_pixels - base`. When the base is at or beyond the image size, the length is zero and the block presents no beat at all.
- R3: At step `i`, element `p` (bits `p*AW +: AW` of `out_addr`) carries address `base + i*NPE + p`.
- R4: Steps are numbered from 0 on `out_iter`. `out_last` is 1 only on step `ceil(len/NPE) - 1`. After that step is accepted, `out_valid` falls.
- R5: Bit `p` of `out_mask` is 1 exactly when `i*NPE + p < len`. Every step except the last therefore has an all-ones mask.
- R6: While `out_valid` is 1 and `out_ready` is 0, the step number, the mask and all addresses hold.
- R7: `pf_valid` is 1 on a beat exactly when `(i + pf_dist) * NPE < len`. `pf_addr` is then `base + (i + pf_dist) * NPE`. No prefetch ever points past the chip's run.
- R8: A `start` pulse takes priority over everything else. It drops `out_valid` on the next cycle, even in the middle of a run, captures the new settings, and restarts numbering at step 0.
- R9: After reset, `out_valid`, `pf_valid`, `out_last` and `out_mask` are all 0.
- R10: The step counter spans the whole address range. With the default parameters, an image of 4096 pixels on one chip runs to step 1023 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture settings and begin a new run |
| chip_idx | input | CW | This chip's number, below `num_chips` |
| num_chips | input | CW | Number of chips sharing the image, at least 1 |
| img_pixels | input | AW | Image size in pixels |
| pf_dist | input | DW | Prefetch look-ahead in steps |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | A step is presented |
| out_addr | output | NPE*AW | Element addresses, element `p` at bits `p*AW +: AW` |
| out_mask | output | NPE | Per-element valid bits |
| out_iter | output | AW-log2(NPE)+1 | Step number |
| out_last | output | 1 | Final step of the run |
| pf_valid | output | 1 | Look-ahead address is meaningful |
| pf_addr | output | AW | First pixel of the step `pf_dist` ahead |

## Verification
The embedded properties assume that `num_chips` is at least 1 and `chip_idx` is below it, because a zero divisor gives a meaningless run. They also assume that settings only change with a `start` pulse. The bench only issues configurations that meet these assumptions: it sweeps chip counts from 1 to 4, every legal chip number for each count, several image sizes and several look-ahead distances. It drives `start` only as a single-cycle pulse, with `out_ready` low in that cycle. A pseudo-random ready pattern creates stalls, so the hold property and the step-advance property are both exercised across every configuration.

// File: rtl/vpix_addr_gen.sv
module vpix_addr_gen #(
  parameter int NPE = 4,
  parameter int AW  = 16,
  parameter int CW  = 4,
  parameter int DW  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [CW-1:0]             chip_idx,
  input  logic [CW-1:0]             num_chips,
  input  logic [AW-1:0]             img_pixels,
  input  logic [DW-1:0]             pf_dist,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [NPE*AW-1:0]         out_addr,
  output logic [NPE-1:0]            out_mask,
  output logic [AW-$clog2(NPE):0]   out_iter,
  output logic                      out_last,
  output logic                      pf_valid,
  output logic [AW-1:0]             pf_addr
);
  localparam int LP = $clog2(NPE);
  localparam int IW = AW - LP + 1;
  localparam int WW = AW + CW + 2;
  localparam int TW = IW + DW;
  localparam int NC = $clog2(AW + 2);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN, S_RUN} st_t;
  st_t st;

  logic [CW-1:0] k_r, chip_r, rm;
  logic [AW-1:0] img_r, base_r, len_r;
  logic [DW-1:0] dist_r;
  logic [AW:0]   nm, q;
  logic [NC-1:0] cnt;
  logic [IW-1:0] iter, lastit_r;

  logic [CW:0] trial, rm_n;
  logic        qb;
  assign trial = {rm, nm[AW]};
  assign qb    = trial >= {1'b0, k_r};
  assign rm_n  = qb ? trial - {1'b0, k_r} : trial;

  logic [WW-1:0] base_w, end_w;
  logic [AW-1:0] len_w;
  assign base_w = WW'(chip_r) * WW'(q);
  assign end_w  = base_w + WW'(q);
  assign len_w  = (base_w >= WW'(img_r)) ? '0 :
                  (end_w > WW'(img_r))   ? AW'(WW'(img_r) - base_w) : AW'(q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; k_r <= '0; chip_r <= '0; img_r <= '0; dist_r <= '0;
      nm <= '0; q <= '0; rm <= '0; cnt <= '0; iter <= '0;
      base_r <= '0; len_r <= '0; lastit_r <= '0;
    end else if (start) begin
      st <= S_DIV; k_r <= num_chips; chip_r <= chip_idx; img_r <= img_pixels;
      dist_r <= pf_dist; rm <= '0; q <= '0; cnt <= '0; iter <= '0;
      nm <= {1'b0, img_pixels} + (AW+1)'(num_chips) - (AW+1)'(1);
    end else begin
      case (st)
        S_DIV: begin
          rm  <= rm_n[CW-1:0];
          q   <= {q[AW-1:0], qb};
          nm  <= nm << 1;
          cnt <= cnt + NC'(1);
          if (cnt == NC'(AW)) st <= S_FIN;
        end
        S_FIN: begin
          base_r   <= base_w[AW-1:0];
          len_r    <= len_w;
          lastit_r <= IW'(({1'b0, len_w} - (AW+1)'(1)) >> LP);
          st       <= (len_w == '0) ? S_IDLE : S_RUN;
        end
        S_RUN: if (out_ready) begin
          if (iter == lastit_r) st <= S_IDLE;
          else iter <= iter + IW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic          run;
  logic [AW:0]   off_w;
  assign run       = (st == S_RUN);
  assign off_w     = {iter, {LP{1'b0}}};
  assign out_valid = run;
  assign out_iter  = iter;
  assign out_last  = run && (iter == lastit_r);

  for (genvar p = 0; p < NPE; p++) begin : g_pe
    logic [AW:0] rel;
    assign rel = off_w + (AW+1)'(p);
    assign out_addr[p*AW +: AW] = base_r + rel[AW-1:0];
    assign out_mask[p] = run && (rel < {1'b0, len_r});
  end

  logic [TW-1:0]    tgt;
  logic [TW+LP-1:0] tof;
  assign tgt      = TW'(iter) + TW'(dist_r);
  assign tof      = {tgt, {LP{1'b0}}};
  assign pf_valid = run && (tof < (TW+LP)'(len_r));
  assign pf_addr  = AW'(tof + (TW+LP)'(base_r));

  initial assert (NPE >= 2 && (1 << LP) == NPE) else $error("NPE must be a power of two");

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=> out_valid && $stable(out_iter) && $stable(out_addr) && $stable(out_mask));
  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last && !start |=> out_valid && out_iter == $past(out_iter) + IW'(1));
  a_r4_end: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last && !start |=> !out_valid);
  a_r5_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> &out_mask);
  a_r5_first_lane: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mask[0]);
  a_r7_pf_inside: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> out_valid && out_mask[0]);
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_valid && out_iter == '0);
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_mask == '0 && !pf_valid && !out_last);
endmodule

// File: tb/sim_vpix_addr_gen.sv
module sim_vpix_addr_gen;
  localparam int TCLK = 10;
  localparam int NPE = 4, AW = 16, CW = 4, DW = 4;
  localparam int IW = AW - $clog2(NPE) + 1;

  logic clk = 0, rst_n = 0, start = 0, out_ready = 0;
  logic [CW-1:0] chip_idx = '0, num_chips = 4'd1;
  logic [AW-1:0] img_pixels = '0;
  logic [DW-1:0] pf_dist = '0;
  logic out_valid, out_last, pf_valid;
  logic [NPE*AW-1:0] out_addr;
  logic [NPE-1:0] out_mask;
  logic [IW-1:0] out_iter;
  logic [AW-1:0] pf_addr;

  vpix_addr_gen #(.NPE(NPE), .AW(AW), .CW(CW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .chip_idx(chip_idx), .num_chips(num_chips),
    .img_pixels(img_pixels), .pf_dist(pf_dist), .out_ready(out_ready), .out_valid(out_valid),
    .out_addr(out_addr), .out_mask(out_mask), .out_iter(out_iter), .out_last(out_last),
    .pf_valid(pf_valid), .pf_addr(pf_addr));

  always #(TCLK/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int img, input int k, input int chip, input int d, input int abort_after);
    int chunk, base, len, nit, beats, cyc, held, h_iter, h_a0;
    chunk = (img + k - 1) / k;
    base  = chip * chunk;
    len   = (base >= img) ? 0 : ((chunk < img - base) ? chunk : img - base);
    nit   = (len + NPE - 1) / NPE;
    @(negedge clk);
    start = 1; out_ready = 0;
    img_pixels = AW'(img); num_chips = CW'(k); chip_idx = CW'(chip); pf_dist = DW'(d);
    @(negedge clk);
    start = 0;
    check(!out_valid, "R8 valid low after start", out_valid, 0);
    beats = 0; held = 0; h_iter = 0; h_a0 = 0;
    if (nit == 0) begin
      repeat (2*AW + 8) begin
        @(negedge clk);
        if (out_valid) break;
      end
      check(!out_valid, "R2 empty portion gives no beat", out_valid, 0);
      return;
    end
    cyc = 0;
    while (beats < nit && cyc < 100 + nit * 20) begin
      @(negedge clk);
      cyc++;
      out_ready = lfsr[0] | lfsr[3];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (out_valid && !out_ready) begin
        if (held != 0) begin
          check(out_iter == IW'(h_iter), "R6 iter held", out_iter, h_iter);
          check(out_addr[AW-1:0] == AW'(h_a0), "R6 addr held", out_addr[AW-1:0], h_a0);
        end
        held = 1; h_iter = int'(out_iter); h_a0 = int'(out_addr[AW-1:0]);
      end
      if (out_valid && out_ready) begin
        int i, t;
        i = beats; t = i + d;
        held = 0;
        check(out_iter == IW'(i), "R4 step number", out_iter, i);
        check(out_last == (i == nit - 1), "R4 last flag", out_last, i == nit - 1);
        for (int p = 0; p < NPE; p++) begin
          check(out_addr[p*AW +: AW] == AW'(base + i*NPE + p), "R3 R1 element address",
                out_addr[p*AW +: AW], base + i*NPE + p);
          check(out_mask[p] == (i*NPE + p < len), "R5 mask bit", out_mask[p], i*NPE + p < len);
        end
        check(pf_valid == (t*NPE < len), "R7 prefetch valid", pf_valid, t*NPE < len);
        if (t*NPE < len)
          check(pf_addr == AW'(base + t*NPE), "R7 prefetch address", pf_addr, base + t*NPE);
        beats++;
        if (beats == abort_after) return;
      end
    end
    check(beats == nit, "R4 beat count", beats, nit);
    @(negedge clk);
    out_ready = 0;
    check(!out_valid, "R4 valid falls after last", out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int imgs[5] = '{1, 3, 8, 13, 22};
    int ds[3] = '{0, 1, 3};
    repeat (3) @(negedge clk);
    check(!out_valid && !pf_valid && !out_last && out_mask == '0, "R9 reset state", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid && out_mask == '0, "R9 idle after reset", out_valid, 0);
    foreach (imgs[a])
      for (int k = 1; k <= 4; k++)
        for (int c = 0; c < k; c++)
          foreach (ds[b]) run(imgs[a], k, c, ds[b], 0);
    run(1000, 3, 1, 5, 0);
    run(4096, 1, 0, 2, 0);                 // R10: steps 0..1023
    run(40, 1, 0, 1, 3);                   // R8: abort mid-run
    run(13, 3, 2, 2, 0);
    run(57, 2, 1, 15, 0);                  // R7: look-ahead past the end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule